// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the controller side of a two-wire serial bus. It recovers a bus on which a target has been left mid-transfer, for example after a controller reset, and is holding the data line low. One pulse on `go` makes the block run a fixed pattern on the clock and data lines. The pattern is a START, then nine clock pulses with the data line released, then a second START, then a STOP. After the STOP it waits out the bus-free time and raises `done`.

Both lines are open drain. An output of 1 means "pull the line low" and an output of 0 means "release the line". The block never drives a line high. Every phase length is a whole number of system clock cycles. Each length is derived from a nanosecond minimum and the `CLK_NS` parameter, using either the standard or the fast timing profile. While the nine pulses run, the block samples the released data line once per pulse. The result is a 9-bit record that shows when the stuck target let go.

Top module: `busclr_seq`

## Requirements
- R1: Immediately after reset, `scl_pull`, `sda_pull`, `busy`, `done` and every bit of `sda_trace` are 0.
- R2: One accepted `go` produces, in this order, exactly: a START, `DUMMY_CLKS` (default 9) complete SCL high pulses during which `sda_pull` stays 0, a second START, and a STOP.
- R3: `sda_pull` changes while SCL is released, in both the old cycle and the new one, only three times per sequence. The first two changes are 0 to 1 (START, START) and the third is 1 to 0 (STOP). Every other data change happens while `scl_pull` is 1.
- R4: Each phase lasts ceil(t/`CLK_NS`) cycles, and never less than 1. The phases are:
  - START setup: 600 ns standard, 250 ns fast.
  - START hold: 600 ns standard, 250 ns fast.
  - SCL low: 1300 ns standard, 400 ns fast.
  - SCL high: 600 ns standard, 400 ns fast.
  - STOP-side hold: the larger of START hold and STOP setup.
  - Bus free: 1300 ns standard, 500 ns fast.
  
  The first SCL low phase lasts one extra cycle. In that cycle SDA is still pulled, and it is released in the next cycle.
- R5: `fast_sel` is sampled in the cycle `go` is accepted: 1 selects the fast profile and 0 the standard profile. Changing `fast_sel` during a sequence has no effect on that sequence.
- R6: After the STOP, both lines stay released for the full bus-free time before `done` rises. `done` then stays 1 until the next accepted `go`.
- R7: `sda_trace[i]` holds the value of `sda_in` in the last cycle of high pulse i, where i=0 is the first pulse. All bits are cleared when a `go` is accepted.
- R8: A `go` that arrives while `busy` is 1 is ignored. The waveform continues exactly as it would have without it.
- R9: `busy` is 1 from the cycle after `go` is accepted until the cycle in which `done` rises. `busy` and `done` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start a recovery sequence (ignored while busy) |
| fast_sel | input | 1 | 1 selects fast timing, 0 standard, sampled at go |
| sda_in | input | 1 | Sampled level of the data line |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished and bus-free time honoured |
| sda_trace | output | DUMMY_CLKS | Data line sampled at the end of each recovery pulse |

## Verification
The bench builds the block with `CLK_NS` = 40 and `DUMMY_CLKS` = 9. At that period several minimum times do not divide evenly: 250 ns, 1300 ns and 500 ns become 7, 33 and 13 cycles. This exposes any rounding error in the phase lengths in both profiles, while a full standard sequence still stays under 600 cycles. A modelled target holds SDA low for a chosen number of pulses, from 0 to 9, which makes the recorded trace, both ends included, depend on that count.

// File: rtl/busclr_pkg.sv
`timescale 1ns/1ps
package busclr_pkg;

  // Minimum bus times in ns, standard and fast profile.
  localparam int unsigned NS_LOW_STD   = 1300;
  localparam int unsigned NS_LOW_FAST  = 400;
  localparam int unsigned NS_HIGH_STD  = 600;
  localparam int unsigned NS_HIGH_FAST = 400;
  localparam int unsigned NS_STA_STD   = 600;
  localparam int unsigned NS_STA_FAST  = 250;
  localparam int unsigned NS_STO_STD   = 600;
  localparam int unsigned NS_STO_FAST  = 250;
  localparam int unsigned NS_FREE_STD  = 1300;
  localparam int unsigned NS_FREE_FAST = 500;
  localparam int unsigned NUM_PHASES   = 10;

  typedef enum logic [3:0] {
    PH_IDLE, PH_SU1, PH_HD1, PH_LOWA, PH_LOW,
    PH_HIGH, PH_LOWE, PH_SU2, PH_HD2, PH_BUF
  } phase_t;

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  function automatic int unsigned phase_ns(phase_t ph, logic fast);
    case (ph)
      PH_SU1, PH_SU2:  return fast ? NS_STA_FAST : NS_STA_STD;
      PH_HD1:          return fast ? NS_STA_FAST : NS_STA_STD;
      PH_HD2:          return fast ? umax(NS_STA_FAST, NS_STO_FAST)
                                   : umax(NS_STA_STD, NS_STO_STD);
      PH_LOW, PH_LOWE: return fast ? NS_LOW_FAST : NS_LOW_STD;
      PH_HIGH:         return fast ? NS_HIGH_FAST : NS_HIGH_STD;
      PH_BUF:          return fast ? NS_FREE_FAST : NS_FREE_STD;
      default:         return 0;
    endcase
  endfunction

  function automatic int unsigned phase_cycles(phase_t ph, logic fast, int unsigned clk_ns);
    return ns_to_cyc(phase_ns(ph, fast), clk_ns);
  endfunction

  function automatic int unsigned max_cycles(int unsigned clk_ns);
    int unsigned m;
    m = 1;
    for (int p = 0; p < int'(NUM_PHASES); p++) begin
      m = umax(m, phase_cycles(phase_t'(p), 1'b0, clk_ns));
      m = umax(m, phase_cycles(phase_t'(p), 1'b1, clk_ns));
    end
    return m;
  endfunction

endpackage

// File: rtl/busclr_timer.sv
`timescale 1ns/1ps
module busclr_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else if (run) cnt_q <= cnt_q + CW'(1);
  end

  assign last = (cnt_q == len - CW'(1));
endmodule

// File: rtl/busclr_trace.sv
`timescale 1ns/1ps
module busclr_trace #(
  parameter int unsigned N  = 9,
  parameter int unsigned IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          sample,
  input  logic [IW-1:0] idx,
  input  logic          din,
  output logic [N-1:0]  trace
);
  for (genvar i = 0; i < int'(N); i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              trace[i] <= 1'b0;
      else if (clr)                            trace[i] <= 1'b0;
      else if (sample && idx == IW'(i))        trace[i] <= din;
    end
  end
endmodule

// File: rtl/busclr_seq.sv
`timescale 1ns/1ps
module busclr_seq #(
  parameter int unsigned CLK_NS     = 10,
  parameter int unsigned DUMMY_CLKS = 9
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go,
  input  logic                  fast_sel,
  input  logic                  sda_in,
  output logic                  scl_pull,
  output logic                  sda_pull,
  output logic                  busy,
  output logic                  done,
  output logic [DUMMY_CLKS-1:0] sda_trace
);
  import busclr_pkg::*;

  localparam int unsigned MAXC = max_cycles(CLK_NS);
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned IW   = (DUMMY_CLKS > 1) ? $clog2(DUMMY_CLKS) : 1;

  phase_t        ph_q, ph_d;
  logic          fast_q;
  logic [IW-1:0] idx_q;
  logic          done_q;
  logic [CW-1:0] cur_len;

  // Named internal events (also observed by the bound checker)
  logic accept, ph_last, ph_adv, ev_sample, in_dummy, last_pulse;

  assign busy       = (ph_q != PH_IDLE);
  assign accept     = go && !busy;
  assign ph_adv     = busy && ph_last;
  assign ev_sample  = (ph_q == PH_HIGH) && ph_last;
  assign in_dummy   = (ph_q == PH_LOW) || (ph_q == PH_HIGH);
  assign last_pulse = (idx_q == IW'(DUMMY_CLKS - 1));
  assign cur_len    = CW'(phase_cycles(ph_q, fast_q, CLK_NS));

  busclr_timer #(.CW(CW)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept | ph_adv),
    .run  (busy),
    .len  (cur_len),
    .last (ph_last)
  );

  always_comb begin
    ph_d = ph_q;
    if (accept) ph_d = PH_SU1;
    else if (ph_adv) begin
      case (ph_q)
        PH_SU1:  ph_d = PH_HD1;
        PH_HD1:  ph_d = PH_LOWA;
        PH_LOWA: ph_d = PH_LOW;
        PH_LOW:  ph_d = PH_HIGH;
        PH_HIGH: ph_d = last_pulse ? PH_LOWE : PH_LOW;
        PH_LOWE: ph_d = PH_SU2;
        PH_SU2:  ph_d = PH_HD2;
        PH_HD2:  ph_d = PH_BUF;
        default: ph_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      fast_q <= 1'b0;
      idx_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q <= ph_d;
      if (accept) begin
        fast_q <= fast_sel;
        idx_q  <= '0;
        done_q <= 1'b0;
      end else begin
        if (ev_sample && !last_pulse) idx_q <= idx_q + IW'(1);
        if (ph_adv && ph_q == PH_BUF) done_q <= 1'b1;
      end
    end
  end

  busclr_trace #(.N(DUMMY_CLKS), .IW(IW)) u_trace (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (accept),
    .sample(ev_sample),
    .idx   (idx_q),
    .din   (sda_in),
    .trace (sda_trace)
  );

  assign scl_pull = (ph_q == PH_LOWA) || (ph_q == PH_LOW) || (ph_q == PH_LOWE);
  assign sda_pull = (ph_q == PH_HD1) || (ph_q == PH_LOWA) || (ph_q == PH_HD2);
  assign done     = done_q;
endmodule

// File: rtl/busclr_chk.sv
`timescale 1ns/1ps
module busclr_chk #(
  parameter int unsigned CLK_NS = 10,
  parameter int unsigned N      = 9
) (
  input logic         clk,
  input logic         rst_n,
  input logic         go,
  input logic         scl_pull,
  input logic         sda_pull,
  input logic         busy,
  input logic         done,
  input logic [N-1:0] trace,
  input logic         in_dummy,
  input logic         ev_sample
);
  import busclr_pkg::*;

  localparam int unsigned LOW_LIM = ns_to_cyc(NS_LOW_STD, CLK_NS) + 1;

  logic        past_ok;
  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      past_ok <= 1'b0;
      low_run <= '0;
    end else begin
      past_ok <= 1'b1;
      if (!scl_pull)            low_run <= '0;
      else if (low_run != '1)   low_run <= low_run + 16'd1;
    end
  end

  // R1 / R9: lines are released whenever no sequence runs
  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_pull && !sda_pull));

  // R2: data stays released through the recovery pulses
  assert_dummy_sda_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_dummy |-> !sda_pull);

  // R3: inside the pulse train SDA never moves while SCL is released
  assert_no_sda_move_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && in_dummy && $past(in_dummy) && !scl_pull && !$past(scl_pull))
      |-> (sda_pull == $past(sda_pull)));

  // R4: no SCL low stretch longer than the longest low phase
  assert_low_window_R4: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull |-> (low_run < 16'(LOW_LIM)));

  // R6: done rises only after a cycle with both lines released
  assert_done_after_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $rose(done)) |-> ($past(!scl_pull) && $past(!sda_pull)));

  // R9: busy and done are exclusive
  assert_busy_done_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R7: record changes only on a pulse sample or a new start
  assert_trace_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(ev_sample) && !$past(go && !busy)) |-> $stable(trace));
endmodule

bind busclr_seq busclr_chk #(.CLK_NS(CLK_NS), .N(DUMMY_CLKS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .go       (go),
  .scl_pull (scl_pull),
  .sda_pull (sda_pull),
  .busy     (busy),
  .done     (done),
  .trace    (sda_trace),
  .in_dummy (in_dummy),
  .ev_sample(ev_sample)
);

// File: tb/sim_busclr_seq.sv
`timescale 1ns/1ps
module sim_busclr_seq;
  localparam int CLK_NS     = 40;
  localparam int CLK_PERIOD = CLK_NS;
  localparam int NPULSE     = 9;
  localparam int NSEG       = 2 * NPULSE + 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic go = 1'b0;
  logic fast_sel = 1'b0;
  logic tgt_low = 1'b0;
  logic sda_in;
  logic scl_pull, sda_pull, busy, done;
  logic [NPULSE-1:0] sda_trace;

  assign sda_in = !sda_pull && !tgt_low;

  always #(CLK_PERIOD/2) clk = ~clk;

  busclr_seq #(.CLK_NS(CLK_NS), .DUMMY_CLKS(NPULSE)) u0 (
    .clk(clk), .rst_n(rst_n), .go(go), .fast_sel(fast_sel), .sda_in(sda_in),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .busy(busy), .done(done),
    .sda_trace(sda_trace)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
  endtask

  // Expected waveform model
  int         e_len [NSEG];
  logic [1:0] e_pat [NSEG];   // {scl pulled, sda pulled}
  int         e_total;

  function automatic int cyc(int ns);
    int n = 0;
    while (n * CLK_NS < ns) n++;
    return (n < 1) ? 1 : n;
  endfunction

  task automatic build_exp(input bit fast);
    int k = 0;
    int t_sta  = fast ? 250 : 600;
    int t_sto  = fast ? 250 : 600;
    int t_low  = fast ? 400 : 1300;
    int t_high = fast ? 400 : 600;
    int t_free = fast ? 500 : 1300;
    e_len[k] = cyc(t_sta); e_pat[k] = 2'b00; k++;
    e_len[k] = cyc(t_sta); e_pat[k] = 2'b01; k++;
    e_len[k] = 1;          e_pat[k] = 2'b11; k++;
    for (int i = 0; i < NPULSE; i++) begin
      e_len[k] = cyc(t_low);  e_pat[k] = 2'b10; k++;
      e_len[k] = cyc(t_high); e_pat[k] = 2'b00; k++;
    end
    e_len[k] = cyc(t_low); e_pat[k] = 2'b10; k++;
    e_len[k] = cyc(t_sta); e_pat[k] = 2'b00; k++;
    e_len[k] = (t_sta > t_sto) ? cyc(t_sta) : cyc(t_sto); e_pat[k] = 2'b01; k++;
    e_len[k] = cyc(t_free); e_pat[k] = 2'b00; k++;
    e_total = 0;
    for (int i = 0; i < NSEG; i++) e_total += e_len[i];
  endtask

  function automatic logic [1:0] exp_at(int t);
    int acc = 0;
    for (int i = 0; i < NSEG; i++) begin
      if (t < acc + e_len[i]) return e_pat[i];
      acc += e_len[i];
    end
    return 2'b00;
  endfunction

  task automatic do_run(input bit fast, input int hold_k, input bit mid_go, input bit flip);
    int wave_bad = 0, busy_bad = 0, done_bad = 0;
    int first_bad_t = -1;
    logic [1:0] first_act = 2'b00, first_exp = 2'b00;
    int starts = 0, stops = 0, pulses = 0, highs = 0;
    bit order_ok = 1, in_high = 0;
    logic prev_scl = 1'b0, prev_sda = 1'b0;
    logic [NPULSE-1:0] exp_trace;
    build_exp(fast);
    for (int i = 0; i < NPULSE; i++) exp_trace[i] = (i >= hold_k);
    tgt_low = 1'b0;
    @(negedge clk); fast_sel = fast; go = 1'b1;
    @(negedge clk); go = 1'b0;
    for (int t = 0; t < e_total + 3; t++) begin
      logic [1:0] ex;
      ex = exp_at(t);
      if ({scl_pull, sda_pull} !== ex) begin
        wave_bad++;
        if (first_bad_t < 0) begin
          first_bad_t = t; first_act = {scl_pull, sda_pull}; first_exp = ex;
        end
      end
      if (busy !== (t < e_total)) busy_bad++;
      if (done !== (t >= e_total)) done_bad++;
      // bus condition bookkeeping
      if (!prev_scl && !scl_pull && (prev_sda != sda_pull)) begin
        if (sda_pull) starts++;
        else begin
          stops++;
          if (starts != 2) order_ok = 0;
        end
      end
      if (prev_scl && !scl_pull) begin
        highs++;
        if (starts == 1) in_high = 1;
      end
      if (!prev_scl && scl_pull && in_high && starts == 1) begin
        pulses++;
        in_high = 0;
      end
      prev_scl = scl_pull;
      prev_sda = sda_pull;
      // modelled stuck target: pulls SDA through the first hold_k pulses
      tgt_low = (highs >= 1) && (highs <= hold_k);
      if (mid_go) go = (t == 50);
      if (flip && t == 60) fast_sel = !fast;
      @(negedge clk);
    end
    go = 1'b0;
    tgt_low = 1'b0;
    check(wave_bad == 0, "R4", $sformatf("waveform fast=%0d t=%0d", fast, first_bad_t),
          first_act, first_exp);
    if (flip)   check(wave_bad == 0, "R5", "profile changed mid-run", wave_bad, 0);
    if (mid_go) check(wave_bad == 0, "R8", "go while busy altered waveform", wave_bad, 0);
    check(busy_bad == 0, "R9", "busy window mismatches", busy_bad, 0);
    check(done_bad == 0, "R6", "done timing mismatches", done_bad, 0);
    check(starts == 2 && stops == 1 && order_ok, "R3",
          "start/stop count (starts*10+stops)", starts * 10 + stops, 21);
    check(pulses == NPULSE, "R2", "recovery pulses between starts", pulses, NPULSE);
    check(sda_trace === exp_trace, "R7", $sformatf("trace hold=%0d", hold_k),
          sda_trace, exp_trace);
    repeat (4) @(negedge clk);
    check(done === 1'b1 && !scl_pull && !sda_pull, "R6", "done held while idle",
          {done, scl_pull, sda_pull}, 3'b100);
    fast_sel = fast;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd20240917);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl_pull === 1'b0, "R1", "scl_pull after reset", scl_pull, 0);
    check(sda_pull === 1'b0, "R1", "sda_pull after reset", sda_pull, 0);
    check(busy === 1'b0, "R1", "busy after reset", busy, 0);
    check(done === 1'b0, "R1", "done after reset", done, 0);
    check(sda_trace === '0, "R1", "trace after reset", sda_trace, 0);
    // directed corners
    do_run(1'b0, 0, 1'b0, 1'b0);
    do_run(1'b1, NPULSE, 1'b0, 1'b0);
    do_run(1'b0, 3, 1'b1, 1'b0);
    do_run(1'b1, 5, 1'b0, 1'b1);
    do_run(1'b0, NPULSE, 1'b1, 1'b1);
    // random runs
    for (int r = 0; r < 6; r++) begin
      bit f, mg, fl;
      int k;
      f  = 1'($urandom % 2);
      k  = int'($urandom % (NPULSE + 1));
      mg = 1'($urandom % 2);
      fl = 1'($urandom % 2);
      do_run(f, k, mg, fl);
    end
    finished = 1;
    summary();
    $finish;
  end
endmodule